// File: doc/BRIEF.md
# Banked Glitch-Free Clock Fanout Gate

This block copies one reference clock onto eight output pairs. Each pair has a true line, a complement line and a drive flag. The pairs are grouped into four banks of two. Each bank has its own active-low enable input, which may change at any time with no relation to the clock. A bank stops or resumes its two pairs only at clean clock boundaries, so no runt pulse reaches a downstream receiver, and the change always lands within a fixed number of output clock periods.

Each enable input first passes through a multi-flop synchronizer. A per-bank state machine then acts on the synchronized request. It has three states. `S_OFF` means the bank is stopped. `S_WAKE` is a fixed hold-off count before restart. `S_ON` means the bank is running. The transitions are:

- `S_OFF`→`S_WAKE` when a run request is seen.
- `S_WAKE`→`S_ON` when the hold-off count reaches its end.
- `S_WAKE`→`S_OFF` when the request is withdrawn during the hold-off.
- `S_ON`→`S_OFF` when the request drops.

The true-line gate is a flop on the falling clock edge, so it changes only while the clock is low. The complement-line gate is a flop on the rising edge that follows the true-line gate, so it changes only while the complement line is low. Analog levels, current setting and termination are not modelled.

Top module: `fanout_gate_top`

## Requirements
- R1: Enable bit b controls output pairs 2b and 2b+1, and both pairs of a bank always carry identical values.
- R2: An enable level of 0 requests that the bank run and 1 requests that it stop. The input is treated as asynchronous and passes through SYNC_STAGES (default 2) synchronizer flops before it acts.
- R3: While a bank runs, its true lines equal the reference clock, its complement lines equal the inverted clock, and its drive flags are 1.
- R4: While a bank is stopped, both its true and complement lines are 0 and its drive flags are 0.
- R5: Disable timing. When a bank's enable changes 0→1 between a falling edge and the next rising edge, rising edges 1 to SYNC_STAGES+1 after the change still carry full pulses. From rising edge SYNC_STAGES+2 (4 by default) the true lines stay low. The default is within 12 periods.
- R6: Enable timing. When a bank's enable changes 1→0 in the same way, the first true-line pulse starts on rising edge SYNC_STAGES+WAKE_CYCLES+2 (6 by default). The defaults keep this between 4 and 12 periods.
- R7: Every high phase on any true or complement line lasts exactly half a clock period. Every low phase lasts at least half a period.
- R8: If a stopped bank's enable goes to 0 and returns to 1 after k rising edges, with 1 ≤ k ≤ WAKE_CYCLES, the bank emits no pulse. It follows the newest level.
- R9: A change on one bank's enable leaves the outputs of every other bank unchanged.
- R10: While rst_n is low, all lines and drive flags are 0. Synchronizers reset to the enabled level, so a bank whose enable stays 0 through reset gives its first pulse on rising edge WAKE_CYCLES+2 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock to be fanned out |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_en_n | input | 4 | Per-bank active-low enable, asynchronous |
| clk_out_p | output | 8 | True line of each output pair |
| clk_out_n | output | 8 | Complement line of each output pair |
| drive_on | output | 8 | Per-pair flag, 1 while the pair's drivers are active |

## Verification
The hardest situation to reach is an enable request withdrawn while its bank sits in the hold-off state. The timing window is only WAKE_CYCLES edges wide, and no output shows that the state was ever entered. The stimulus releases the enable just after a falling edge, counts exactly k rising edges for each k in the window, and restores the stop level. It then watches sixteen edges for any true-line pulse. Pulse-width monitors on all sixteen lines run during every sweep step, so a runt caused by a gate that switches at the wrong edge is caught wherever it appears.

// File: rtl/fanout_gate_pkg.sv
`timescale 1ns/1ps
package fanout_gate_pkg;

    // Per-bank gating state
    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_WAKE = 2'd1,
        S_ON   = 2'd2
    } bank_state_e;

endpackage

// File: rtl/enable_sync.sv
`timescale 1ns/1ps
module enable_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level_q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Reset value 0 is the enabled level (R10)
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign level_q = stage_q[STAGES-1];

endmodule

// File: rtl/bank_gate.sv
`timescale 1ns/1ps
module bank_gate
    import fanout_gate_pkg::*;
#(
    parameter int PAIRS       = 2,
    parameter int WAKE_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_req,
    output logic [PAIRS-1:0] line_p,
    output logic [PAIRS-1:0] line_n,
    output logic [PAIRS-1:0] drv
);

    localparam int CNT_W = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYCLES - 1);

    bank_state_e      state_q, state_d;
    logic [CNT_W-1:0] wake_cnt_q;
    logic             gate_p_q;
    logic             gate_n_q;

    // State register and hold-off counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_OFF;
            wake_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_WAKE) wake_cnt_q <= wake_cnt_q + 1'b1;
            else                   wake_cnt_q <= '0;
        end
    end

    // Next-state logic: a withdrawn request always wins (R8)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF:   if (run_req) state_d = S_WAKE;
            S_WAKE: begin
                if (!run_req)                    state_d = S_OFF;
                else if (wake_cnt_q == WAKE_LAST) state_d = S_ON;
            end
            S_ON:    if (!run_req) state_d = S_OFF;
            default: state_d = S_OFF;
        endcase
    end

    // True-line gate switches on the falling edge, while the clock is low (R7)
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) gate_p_q <= 1'b0;
        else        gate_p_q <= (state_q == S_ON);
    end

    // Complement gate follows on the rising edge, while ~clk is low (R7)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_n_q <= 1'b0;
        else        gate_n_q <= gate_p_q;
    end

    for (genvar i = 0; i < PAIRS; i++) begin : g_pair
        assign line_p[i] = clk & gate_p_q;
        assign line_n[i] = ~clk & gate_n_q;
        assign drv[i]    = gate_p_q | gate_n_q;
    end

    // R2: running state only ever follows a seen run request
    a_r2_on_has_request: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ON) |-> $past(run_req));

    // R5: a dropped request stops a running bank on the next edge
    a_r5_stop_next: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ON && !run_req) |=> (state_q == S_OFF));

    // R8: a withdrawn request abandons the hold-off
    a_r8_abort_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAKE && !run_req) |=> (state_q == S_OFF));

    // R6: running is entered only through the hold-off
    a_r6_on_from_wake: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == S_ON) |-> ($past(state_q) == S_WAKE));

    // R4: a bank stopped for two edges has both gates closed
    a_r4_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OFF && $past(state_q) == S_OFF) |-> (!gate_p_q && !gate_n_q));

endmodule

// File: rtl/fanout_gate_top.sv
`timescale 1ns/1ps
module fanout_gate_top #(
    parameter int BANKS          = 4,
    parameter int PAIRS_PER_BANK = 2,
    parameter int SYNC_STAGES    = 2,
    parameter int WAKE_CYCLES    = 2
) (
    input  logic                              clk_ref,
    input  logic                              rst_n,
    input  logic [BANKS-1:0]                  bank_en_n,
    output logic [BANKS*PAIRS_PER_BANK-1:0]   clk_out_p,
    output logic [BANKS*PAIRS_PER_BANK-1:0]   clk_out_n,
    output logic [BANKS*PAIRS_PER_BANK-1:0]   drive_on
);

    localparam int NUM_PAIRS = BANKS * PAIRS_PER_BANK;

    logic [BANKS-1:0] en_n_sync;

    enable_sync #(
        .WIDTH  (BANKS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .async_in (bank_en_n),
        .level_q  (en_n_sync)
    );

    // R1: bank b owns pairs b*PAIRS_PER_BANK and upward
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bank_gate #(
            .PAIRS       (PAIRS_PER_BANK),
            .WAKE_CYCLES (WAKE_CYCLES)
        ) u_bank (
            .clk     (clk_ref),
            .rst_n   (rst_n),
            .run_req (~en_n_sync[b]),
            .line_p  (clk_out_p[b*PAIRS_PER_BANK +: PAIRS_PER_BANK]),
            .line_n  (clk_out_n[b*PAIRS_PER_BANK +: PAIRS_PER_BANK]),
            .drv     (drive_on[b*PAIRS_PER_BANK +: PAIRS_PER_BANK])
        );
    end

    if (NUM_PAIRS < 1) begin : g_bad_cfg
        initial $error("fanout_gate_top needs at least one pair");
    end

endmodule

// File: tb/fanout_gate_top_test.sv
`timescale 1ns/1ps
module fanout_gate_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int BANKS      = 4;
    localparam int PPB        = 2;
    localparam int NP         = BANKS * PPB;
    localparam int SYNC       = 2;
    localparam int WAKE       = 2;
    localparam int EN_LAT     = SYNC + WAKE + 2;
    localparam int DIS_LAT    = SYNC + 2;
    localparam int RST_LAT    = WAKE + 2;
    localparam realtime HALF  = CLK_PERIOD / 2.0;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [BANKS-1:0] en_n;
    logic [NP-1:0]    out_p, out_n, drv;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fanout_gate_top #(
        .BANKS(BANKS), .PAIRS_PER_BANK(PPB), .SYNC_STAGES(SYNC), .WAKE_CYCLES(WAKE)
    ) uut (
        .clk_ref   (clk),
        .rst_n     (rst_n),
        .bank_en_n (en_n),
        .clk_out_p (out_p),
        .clk_out_n (out_n),
        .drive_on  (drv)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R7: pulse-width monitors on every line
    for (genvar gi = 0; gi < NP; gi++) begin : g_mon
        realtime rise_p = 0, fall_p = 0, rise_n = 0, fall_n = 0;
        bit seen_fp = 0, seen_rp = 0, seen_fn = 0, seen_rn = 0;
        always @(posedge out_p[gi]) begin
            if (seen_fp) chk(($realtime - fall_p) >= HALF, "R7 true low phase",
                             int'($realtime - fall_p), int'(HALF));
            rise_p = $realtime; seen_rp = 1;
        end
        always @(negedge out_p[gi]) begin
            if (seen_rp) chk(($realtime - rise_p) == HALF, "R7 true high phase",
                             int'($realtime - rise_p), int'(HALF));
            fall_p = $realtime; seen_fp = 1;
        end
        always @(posedge out_n[gi]) begin
            if (seen_fn) chk(($realtime - fall_n) >= HALF, "R7 complement low phase",
                             int'($realtime - fall_n), int'(HALF));
            rise_n = $realtime; seen_rn = 1;
        end
        always @(negedge out_n[gi]) begin
            if (seen_rn) chk(($realtime - rise_n) == HALF, "R7 complement high phase",
                             int'($realtime - rise_n), int'(HALF));
            fall_n = $realtime; seen_fn = 1;
        end
    end

    // R1, R3, R4: steady-state levels for a given enable pattern
    task automatic check_steady(input logic [BANKS-1:0] pat);
        @(posedge clk); #1;
        for (int i = 0; i < NP; i++) begin
            logic run;
            run = !pat[i/PPB];
            chk(out_p[i] == run, run ? "R3 true high" : "R4 true low", int'(out_p[i]), int'(run));
            chk(drv[i] == run, run ? "R3 drive flag" : "R4 drive flag", int'(drv[i]), int'(run));
        end
        @(negedge clk); #1;
        for (int i = 0; i < NP; i++) begin
            logic run;
            run = !pat[i/PPB];
            chk(out_n[i] == run, run ? "R3 complement high" : "R4 complement low",
                int'(out_n[i]), int'(run));
            chk(out_p[i] == 1'b0, "R1 true low in low phase", int'(out_p[i]), 0);
        end
    endtask

    task automatic set_pattern(input logic [BANKS-1:0] pat);
        @(negedge clk); #1;
        en_n = pat;
        repeat (20) @(posedge clk);
        @(negedge clk); #1;
    endtask

    // R5, R6, R9: flip one bank and time its response
    task automatic flip_bank(input int b, input logic [BANKS-1:0] pat);
        logic [BANKS-1:0] newp;
        logic target;
        int first;
        int bad;
        newp   = pat ^ (BANKS'(1) << b);
        target = !newp[b];
        first  = 0;
        bad    = 0;
        @(negedge clk); #1;
        en_n = newp;
        for (int n = 1; n <= 14; n++) begin
            @(posedge clk); #1;
            if (first == 0 && out_p[b*PPB] == target && out_p[b*PPB+1] == target) first = n;
            for (int ob = 0; ob < BANKS; ob++) begin
                if (ob != b) begin
                    for (int k = 0; k < PPB; k++)
                        if (out_p[ob*PPB+k] != !pat[ob]) bad++;
                end
            end
        end
        if (target) chk(first == EN_LAT, "R6 enable latency", first, EN_LAT);
        else        chk(first == DIS_LAT, "R5 disable latency", first, DIS_LAT);
        chk(bad == 0, "R9 other banks undisturbed", bad, 0);
        @(negedge clk); #1;
    endtask

    // R8: withdraw an enable after k edges of hold-off
    task automatic abort_bank(input int b, input int k);
        int pulses;
        pulses = 0;
        @(negedge clk); #1;
        en_n[b] = 1'b0;
        repeat (k) @(posedge clk);
        @(negedge clk); #1;
        en_n[b] = 1'b1;
        for (int n = 0; n < 16; n++) begin
            @(posedge clk); #1;
            if (out_p[b*PPB] || out_p[b*PPB+1] || drv[b*PPB]) pulses++;
        end
        chk(pulses == 0, "R8 withdrawn enable emits nothing", pulses, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        en_n  = '0;
        repeat (3) @(negedge clk);
        #1;
        // R10: reset state
        chk(out_p == '0, "R10 true lines in reset", int'(out_p), 0);
        chk(out_n == '0, "R10 complement lines in reset", int'(out_n), 0);
        chk(drv == '0, "R10 drive flags in reset", int'(drv), 0);
        @(posedge clk); #1;
        chk(out_p == '0, "R10 true lines in reset at high phase", int'(out_p), 0);
        @(negedge clk); #1;
        rst_n = 1'b1;
        begin
            int first [NP];
            for (int i = 0; i < NP; i++) first[i] = 0;
            for (int n = 1; n <= 10; n++) begin
                @(posedge clk); #1;
                for (int i = 0; i < NP; i++)
                    if (first[i] == 0 && out_p[i]) first[i] = n;
            end
            for (int i = 0; i < NP; i++)
                chk(first[i] == RST_LAT, "R10 start after reset", first[i], RST_LAT);
        end

        // R2: sweep every enable pattern, flipping each bank
        for (int p = 0; p < (1 << BANKS); p++) begin
            logic [BANKS-1:0] pat;
            pat = BANKS'(p);
            set_pattern(pat);
            check_steady(pat);
            for (int b = 0; b < BANKS; b++) begin
                flip_bank(b, pat);
                check_steady(pat ^ (BANKS'(1) << b));
                flip_bank(b, pat ^ (BANKS'(1) << b));
                check_steady(pat);
            end
        end

        set_pattern('1);
        for (int b = 0; b < BANKS; b++)
            for (int k = 1; k <= WAKE; k++)
                abort_bank(b, k);
        check_steady('1);

        set_pattern('0);
        check_steady('0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule